// File: doc/BRIEF.md
# Programmable Counter/Timer with Selectable Tick Source

This block is a 16-bit down-counter that serves a two-channel asynchronous serial controller. A 3-bit mode field selects both what the block does and where its ticks come from. The tick source is one of four raw inputs: an external pin, the transmit clock of channel A, the transmit clock of channel B, or the crystal clock. Some modes pass that source through a divide-by-16 prescaler first. The block samples all raw sources into the system clock domain, detects their rising edges, and turns them into single-cycle tick enables.

The upper half of the mode codes runs the block as a timer. In a timer mode the count reloads on its own at every terminal count and a square-wave output toggles, so the wave runs freely. The lower half runs it as a one-shot event counter. That counter raises a ready flag when it reaches zero and then keeps counting down past zero. A small write port loads the preload bytes and the mode field. Start and stop strobes control each run. A new mode takes effect only when the next start arrives.

Top module: `ctr_timer`

## Requirements
- R1: While and after reset, `sq_out` and `ready` are 0 and the block stays idle until a start strobe arrives.
- R2: A write with `wr_sel`=0 loads the upper preload byte and `wr_sel`=1 loads the lower byte from `wr_data`. `wr_sel`=2 loads the mode field from `wr_data[2:0]`. `wr_sel`=3 is ignored.
- R3: Mode codes 0 to 3 are counter modes. Code 0 ticks on rising edges of `ext_in`, code 1 on `txa_clk`, code 2 on `txb_clk`, and code 3 on `xtal_clk` divided by 16. In each of these modes the other sources have no effect.
- R4: Mode codes 4 to 7 are timer modes. Code 4 ticks on `ext_in`, code 5 on `ext_in` divided by 16, code 6 on `xtal_clk` undivided, and code 7 on `xtal_clk` divided by 16.
- R5: Each source passes through a two-stage synchronizer, and each low-to-high transition gives exactly one tick however long the level is held. An input edge set up before clock edge k shows at the outputs after edge k+2.
- R6: A divided source yields one tick on every 16th rising edge. A start strobe clears the prescaler.
- R7: In counter mode `ready` sets when the count steps to zero, which happens after exactly preload ticks for a preload of 1 or more. The count then wraps to 0xFFFF and keeps counting with `ready` held. `sq_out` does not change.
- R8: In counter mode a stop strobe halts counting and clears `ready`.
- R9: In timer mode every terminal count (a tick while the count is 1 or less) reloads the preload, toggles `sq_out` and sets `ready`. A full wave period is therefore twice the preload in ticks.
- R10: In timer mode a stop strobe clears `ready` but the square wave keeps running.
- R11: A start strobe loads the preload, latches the mode field, clears `sq_out`, `ready` and the prescaler, and begins a run. When start and stop arrive in the same cycle, start wins.
- R12: Writing the mode field without a start leaves the running mode unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 preload high, 1 preload low, 2 mode |
| wr_data | input | 8 | Write data |
| start | input | 1 | Start / restart strobe |
| stop | input | 1 | Stop strobe |
| ext_in | input | 1 | Raw external source pin |
| txa_clk | input | 1 | Raw channel A transmit clock |
| txb_clk | input | 1 | Raw channel B transmit clock |
| xtal_clk | input | 1 | Raw crystal clock |
| sq_out | output | 1 | Timer square-wave output |
| ready | output | 1 | Terminal-count flag |

## Verification
The hardest conditions to reach from the ports are those that need long runs of source edges. Examples are the 16th-edge ticks of the divided modes, the reload that a preload of 0x0101 reads across both bytes, and the wrap of the counter past zero. The stimulus drives long bursts of edges on one source while the others are pulsed as distractors. It also holds a source high for many cycles to show that one edge gives one tick. Start and stop are fired in the same cycle to exercise their precedence. A behavioural model follows every cycle, so the output is compared at each clock, including the cycles in which the terminal count lands.

// File: rtl/ctr_timer.sv
module ctr_timer #(
  parameter int CW = 16,
  parameter int PW = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_sel,
  input  logic [7:0] wr_data,
  input  logic       start,
  input  logic       stop,
  input  logic       ext_in,
  input  logic       txa_clk,
  input  logic       txb_clk,
  input  logic       xtal_clk,
  output logic       sq_out,
  output logic       ready
);
  localparam logic [CW-1:0] ONE = CW'(1);
  localparam logic [PW-1:0] PMAX = '1;

  logic [3:0] s1, s2, s3, rise;
  logic [CW-1:0] preload, cnt;
  logic [2:0] mode_reg, act_mode;
  logic [PW-1:0] pre;
  logic running, use_div, pre_in, direct, tick, adv, is_timer;
  logic unused_wr;

  assign unused_wr = ^wr_data[7:3];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; s3 <= '0;
    end else begin
      s1 <= {xtal_clk, txb_clk, txa_clk, ext_in};
      s2 <= s1;
      s3 <= s2;
    end

  assign rise = s2 & ~s3;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      preload  <= '0;
      mode_reg <= '0;
    end else if (wr_en) begin
      case (wr_sel)
        2'd0: preload[CW-1:8] <= wr_data[CW-9:0];
        2'd1: preload[7:0]    <= wr_data;
        2'd2: mode_reg        <= wr_data[2:0];
        default: ;
      endcase
    end

  assign is_timer = act_mode[2];
  assign use_div  = (act_mode == 3'd3) || (act_mode == 3'd5) || (act_mode == 3'd7);
  assign pre_in   = (act_mode == 3'd5) ? rise[0] : rise[3];

  always_comb begin
    case (act_mode)
      3'd0, 3'd4: direct = rise[0];
      3'd1:       direct = rise[1];
      3'd2:       direct = rise[2];
      3'd6:       direct = rise[3];
      default:    direct = 1'b0;
    endcase
  end

  assign tick = use_div ? (pre_in && pre == PMAX) : direct;
  assign adv  = running && tick && !(stop && !is_timer);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                pre <= '0;
    else if (start)            pre <= '0;
    else if (use_div && pre_in) pre <= pre + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt      <= '0;
      act_mode <= '0;
      running  <= 1'b0;
      ready    <= 1'b0;
      sq_out   <= 1'b0;
    end else if (start) begin
      cnt      <= preload;
      act_mode <= mode_reg;
      running  <= 1'b1;
      ready    <= 1'b0;
      sq_out   <= 1'b0;
    end else begin
      if (adv) begin
        if (is_timer) begin
          if (cnt <= ONE) begin
            cnt    <= preload;
            sq_out <= ~sq_out;
            ready  <= 1'b1;
          end else begin
            cnt <= cnt - ONE;
          end
        end else begin
          cnt <= cnt - ONE;
          if (cnt == ONE) ready <= 1'b1;
        end
      end
      if (stop) begin
        ready <= 1'b0;
        if (!is_timer) running <= 1'b0;
      end
    end

  p_idle_no_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !ready);
  p_stop_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !start) |=> !ready);
  p_counter_sq_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !is_timer && !start) |=> $stable(sq_out));
  p_ready_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !stop && !start) |=> ready);
  p_start_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cnt == $past(preload)) && !sq_out && !ready && running);
  p_mode_latch_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(act_mode));
  p_timer_stop_runs_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (running && is_timer && stop) |=> running);
endmodule

// File: tb/tb_ctr_timer.sv
`timescale 1ns/1ps
module tb_ctr_timer;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, start = 0, stop = 0;
  logic [1:0] wr_sel = 0;
  logic [7:0] wr_data = 0;
  logic [3:0] src = 0;
  logic sq_out, ready;
  int errors = 0, checks = 0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  ctr_timer dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .start(start), .stop(stop), .ext_in(src[0]),
    .txa_clk(src[1]), .txb_clk(src[2]), .xtal_clk(src[3]),
    .sq_out(sq_out), .ready(ready));

  // behavioural reference
  int m_cnt, m_pre, m_act, m_mode, m_pl;
  bit m_run, m_rdy, m_sq;
  bit hist[4][$];

  always @(posedge clk) begin
    bit r[4];
    bit dv, ps, dr, tk, tm;
    if (!rst_n) begin
      m_cnt = 0; m_pre = 0; m_act = 0; m_mode = 0; m_pl = 0;
      m_run = 0; m_rdy = 0; m_sq = 0;
      for (int i = 0; i < 4; i++) begin
        hist[i].delete();
        hist[i] = '{0, 0, 0};
      end
    end else begin
      for (int i = 0; i < 4; i++) begin
        r[i] = hist[i][1] && !hist[i][2];
        void'(hist[i].pop_back());
        hist[i].push_front(src[i]);
      end
      dv = (m_act == 3 || m_act == 5 || m_act == 7);
      ps = (m_act == 5) ? r[0] : r[3];
      case (m_act)
        0, 4: dr = r[0];
        1: dr = r[1];
        2: dr = r[2];
        6: dr = r[3];
        default: dr = 0;
      endcase
      tk = dv ? (ps && m_pre == 15) : dr;
      if (start) m_pre = 0;
      else if (dv && ps) m_pre = (m_pre + 1) % 16;
      if (start) begin
        m_cnt = m_pl; m_act = m_mode; m_run = 1; m_rdy = 0; m_sq = 0;
      end else begin
        tm = (m_act >= 4);
        if (m_run && tk && !(stop && !tm)) begin
          if (tm) begin
            if (m_cnt <= 1) begin m_cnt = m_pl; m_sq = !m_sq; m_rdy = 1; end
            else m_cnt = m_cnt - 1;
          end else begin
            if (m_cnt == 1) m_rdy = 1;
            m_cnt = (m_cnt + 65535) % 65536;
          end
        end
        if (stop) begin m_rdy = 0; if (!tm) m_run = 0; end
      end
      if (wr_en) begin
        case (wr_sel)
          0: m_pl = (int'(wr_data) << 8) | (m_pl & 255);
          1: m_pl = (m_pl & 16'hFF00) | int'(wr_data);
          2: m_mode = int'(wr_data) & 7;
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) if (rst_n) begin
    checks++;
    if (sq_out !== m_sq || ready !== m_rdy) begin
      errors++;
      $display("FAIL %s model: sq_out=%0b ready=%0b expected sq_out=%0b ready=%0b",
               tag, sq_out, ready, m_sq, m_rdy);
    end
  end

  task automatic chk(input string t, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0b expected=%0b", t, what, act, exp);
    end
  endtask

  task automatic wr(input int sel, input int d);
    wr_en = 1; wr_sel = 2'(sel); wr_data = 8'(d);
    @(negedge clk); wr_en = 0;
  endtask

  task automatic setup(input int mode, input int pl);
    wr(0, pl >> 8); wr(1, pl & 255); wr(2, mode);
  endtask

  task automatic go();
    start = 1; @(negedge clk); start = 0;
  endtask

  task automatic halt();
    stop = 1; @(negedge clk); stop = 0;
  endtask

  task automatic edges(input int idx, input int n);
    for (int k = 0; k < n; k++) begin
      src[idx] = 1; repeat (3) @(negedge clk);
      src[idx] = 0; repeat (3) @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", sq_out, 0, "sq_out in reset"); chk("R1", ready, 0, "ready in reset");
    rst_n = 1;
    edges(0, 3);
    chk("R1", ready, 0, "ready idle before start");

    tag = "R7";
    setup(0, 5); go();
    edges(0, 4); chk("R3", ready, 0, "mode0 after 4 ext edges");
    edges(0, 1); chk("R7", ready, 1, "mode0 after 5 ext edges");
    edges(0, 3); chk("R7", ready, 1, "ready held after wrap");
    chk("R7", sq_out, 0, "sq_out in counter mode");

    tag = "R8";
    halt(); chk("R8", ready, 0, "stop clears ready");
    edges(0, 2); chk("R8", ready, 0, "halted counter stays");

    tag = "R3";
    setup(1, 3); go();
    edges(0, 5); edges(2, 2); chk("R3", ready, 0, "mode1 ignores ext/txb");
    edges(1, 3); chk("R3", ready, 1, "mode1 after 3 txa edges");
    setup(2, 1); go();
    edges(1, 2); chk("R3", ready, 0, "mode2 ignores txa");
    edges(2, 1); chk("R3", ready, 1, "mode2 after 1 txb edge");

    tag = "R6";
    setup(3, 2); go();
    edges(3, 31); chk("R6", ready, 0, "mode3 after 31 xtal edges");
    edges(3, 1);  chk("R6", ready, 1, "mode3 after 32 xtal edges");

    tag = "R9";
    setup(4, 3); go();
    edges(0, 2); chk("R9", sq_out, 0, "timer before terminal");
    edges(0, 1); chk("R9", sq_out, 1, "timer first toggle");
    chk("R9", ready, 1, "ready on terminal");
    tag = "R10";
    halt(); chk("R10", ready, 0, "timer stop clears ready");
    chk("R10", sq_out, 1, "timer stop keeps wave");
    edges(0, 3); chk("R10", sq_out, 0, "wave continues after stop");

    tag = "R4";
    setup(5, 1); go();
    edges(0, 15); chk("R4", sq_out, 0, "mode5 after 15 edges");
    edges(0, 1);  chk("R4", sq_out, 1, "mode5 after 16 edges");
    setup(6, 2); go();
    edges(3, 2); chk("R4", sq_out, 1, "mode6 2 xtal edges");
    edges(0, 3); chk("R4", sq_out, 1, "mode6 ignores ext");
    edges(3, 2); chk("R4", sq_out, 0, "mode6 4 xtal edges");
    setup(7, 1); go();
    edges(3, 16); chk("R4", sq_out, 1, "mode7 16 xtal edges");

    tag = "R12";
    wr(2, 0);
    edges(0, 3); chk("R12", sq_out, 1, "new mode not yet active");
    edges(3, 16); chk("R12", sq_out, 0, "old mode keeps running");

    tag = "R11";
    wr(0, 0); wr(1, 1);
    start = 1; stop = 1; @(negedge clk); start = 0; stop = 0;
    edges(0, 1); chk("R11", ready, 1, "start wins over stop");
    setup(4, 2); go();
    edges(0, 2); chk("R11", sq_out, 1, "timer toggle before restart");
    go(); chk("R11", sq_out, 0, "restart clears wave");
    edges(0, 1); chk("R11", sq_out, 0, "restart reloads count");
    edges(0, 1); chk("R11", sq_out, 1, "restart toggle after preload");

    tag = "R5";
    setup(0, 2); go();
    src[0] = 1; repeat (20) @(negedge clk); src[0] = 0; repeat (3) @(negedge clk);
    chk("R5", ready, 0, "held level counts once");
    src[0] = 1; @(negedge clk); @(negedge clk);
    chk("R5", ready, 0, "no effect after 2 edges");
    @(negedge clk);
    chk("R5", ready, 1, "effect after third edge");
    src[0] = 0; repeat (3) @(negedge clk);

    tag = "R2";
    setup(6, 16'h0101); go();
    wr(3, 7);
    edges(3, 256); chk("R2", sq_out, 0, "preload 0x0101 not reached");
    edges(3, 1);   chk("R2", sq_out, 1, "preload 0x0101 reached");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule